// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs a single processor-side transfer to memory or to an I/O port over a bus whose lines carry first the address and then the data. The requester offers an address, a flag that selects I/O or memory space, a flag that selects write or read, and write data. When the block can take the request, it latches all of these. It then steps through a fixed four-period cycle: address phase, strobe phase, data phase and release phase. It drives the latch enable, the active-low read and write strobes, the data-buffer enable, the transfer direction, the space indicator and the shared lines together with their output enable.

A slow target holds the ready input low to stretch the cycle. The block samples ready at the end of the strobe phase. While ready is low it inserts wait periods and keeps the strobes active. On a read, the sampled bus value is returned with a one-clock done pulse and stays stable afterwards. A parameter selects the polarity of the space indicator. At a 5 MHz clock an unstalled transfer takes 800 ns, which allows at most 1.25 million transfers per second.

Top module: `bus_cycle_seq`

## Requirements
- R1: A request is taken on the rising edge where reqValid and reqAccept are both high. The next four clocks are T1, T2, T3 and T4 when ready is high at the end of T2. rspDone is high only in the fourth of these clocks.
- R2: In T1, ale is 1, adOe is 1, adOut carries the latched address, and rdN, wrN and den are inactive (1, 1, 0). ale is 0 in every other state.
- R3: In T2, T3 and every wait period, den is 1 and the selected strobe is 0 (rdN for a read, wrN for a write). In a write, adOe is 1 and adOut carries the write data, zero-extended in the upper bits, from T2 through T4.
- R4: ready is sampled on the clock edge that ends T2 and on the edge that ends each wait period. If ready is 0, the next clock is a wait period with the strobes and den unchanged and rspDone 0. If ready is 1, the next clock is T3.
- R5: In a read, rspData takes adIn on the edge that ends T3, and so equals it during T4. Values on adIn in T1, T2 and the wait periods are not captured.
- R6: rspData holds its value through write cycles and idle periods. It changes only at the end of a read T3. It is 0 after reset.
- R7: In a read, adOe is 0 from T2 through T4. In the idle state, adOe is 0 for both kinds of cycle.
- R8: In T4 and in idle, rdN and wrN are 1 and den and ale are 0.
- R9: rspDone is a single clock wide for each transfer.
- R10: reqAccept is 1 only in idle and in T4. A request offered in T1 to T3 or in a wait period has no effect on the cycle in progress. A request held through T4 starts T1 on the very next clock.
- R11: From T1 through T4, a memory access drives mio to the value of parameter MEM_HIGH and an I/O access drives it to the inverse. dtR is 1 for a write and 0 for a read.
- R12: rdN and wrN are never 0 in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A transfer request is offered |
| reqAccept | output | 1 | The block takes a request on this edge (idle or T4) |
| reqAddr | input | ADDR_W | Memory address or port number |
| reqIsIo | input | 1 | 1 selects I/O space, 0 selects memory |
| reqWrite | input | 1 | 1 selects write, 0 selects read |
| reqWdata | input | DATA_W | Data to write |
| ready | input | 1 | Target ready; low inserts wait periods |
| ale | output | 1 | Address latch enable, high in T1 |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| den | output | 1 | Data-buffer enable, active high |
| dtR | output | 1 | Direction: 1 transmit (write), 0 receive |
| mio | output | 1 | Memory/I/O indicator, polarity set by MEM_HIGH |
| adOut | output | ADDR_W | Value driven on the shared lines |
| adOe | output | 1 | Output enable of the shared lines |
| adIn | input | DATA_W | Sampled low data lines of the shared bus |
| rspDone | output | 1 | One-clock completion pulse in T4 |
| rspData | output | DATA_W | Captured read data |

## Verification
Two events can fall in the same clock: a new request and the T4 of the cycle in progress. Completion and acceptance then overlap, and the very next clock must already be a fresh T1. The bench provokes this by raising reqValid during T2 with a second address and holding it through T4. It then judges that the strobes and write data of the current cycle are unchanged in T3 and that rspDone appears in T4. Finally, the clock right after T4 must show ale together with the second address. A companion case overlaps a low ready with the end of T2 and of several wait periods. The capture edge is judged by changing adIn in every period except T3.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;   // capture the incoming request
    logic captureRd;  // sample the bus into the read register
    logic driveAddr;  // put the latched address on the shared lines
    logic driveData;  // put the latched write data on the shared lines
  } dpStrobe_t;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      ready,
  input  logic      curWrite,
  output dpStrobe_t strb,
  output logic      reqAccept,
  output logic      cycleActive,
  output logic      ale,
  output logic      rdN,
  output logic      wrN,
  output logic      den,
  output logic      rspDone
);

  busState_e state, stateNext;
  logic strobePhase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_T1;
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ready ? ST_T3 : ST_TW;
      ST_TW:   stateNext = ready ? ST_T3 : ST_TW;
      ST_T3:   stateNext = ST_T4;
      ST_T4:   stateNext = reqValid ? ST_T1 : ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqAccept   = (state == ST_IDLE) || (state == ST_T4);
  assign cycleActive = (state != ST_IDLE);
  assign strobePhase = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);

  always_comb begin
    strb.latchReq  = reqAccept && reqValid;
    strb.captureRd = (state == ST_T3) && !curWrite;
    strb.driveAddr = (state == ST_T1);
    strb.driveData = curWrite && (strobePhase || (state == ST_T4));
  end

  assign ale     = (state == ST_T1);
  assign den     = strobePhase;
  assign rdN     = !(strobePhase && !curWrite);
  assign wrN     = !(strobePhase && curWrite);
  assign rspDone = (state == ST_T4);

  AST_T1_TO_T2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T1) |=> (state == ST_T2)); // R1
  AST_T3_TO_T4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T3) |=> (state == ST_T4)); // R1
  AST_WAIT_ON_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobePhase && (state != ST_T3) && !ready) |=> (state == ST_TW)); // R4
  AST_ADVANCE_ON_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobePhase && (state != ST_T3) && ready) |=> (state == ST_T3)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R9

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
  import bcs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter bit MEM_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic              cycleActive,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsIo,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic              curWrite,
  output logic [ADDR_W-1:0] adOut,
  output logic              mio,
  output logic              dtR,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic              isIoQ;
  logic [ADDR_W-1:0] wdataWide;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      isIoQ    <= 1'b0;
      curWrite <= 1'b0;
    end else if (strb.latchReq) begin
      addrQ    <= reqAddr;
      wdataQ   <= reqWdata;
      isIoQ    <= reqIsIo;
      curWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rspData <= '0;
    else if (strb.captureRd) rspData <= adIn;
  end

  always_comb begin
    wdataWide = '0;
    wdataWide[DATA_W-1:0] = wdataQ;
  end

  always_comb begin
    if (strb.driveAddr)      adOut = addrQ;
    else if (strb.driveData) adOut = wdataWide;
    else                     adOut = '0;
  end

  assign mio = MEM_HIGH ? !isIoQ : isIoQ;
  assign dtR = cycleActive && curWrite;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.captureRd |=> $stable(rspData)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchReq |=> ($stable(addrQ) && $stable(curWrite))); // R10

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 16,
  parameter bit MEM_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqAccept,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsIo,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              ready,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              den,
  output logic              dtR,
  output logic              mio,
  output logic [ADDR_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspData
);

  dpStrobe_t strb;
  logic      curWrite;
  logic      cycleActive;

  bcs_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .ready      (ready),
    .curWrite   (curWrite),
    .strb       (strb),
    .reqAccept  (reqAccept),
    .cycleActive(cycleActive),
    .ale        (ale),
    .rdN        (rdN),
    .wrN        (wrN),
    .den        (den),
    .rspDone    (rspDone)
  );

  bcs_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .MEM_HIGH(MEM_HIGH)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cycleActive(cycleActive),
    .reqAddr    (reqAddr),
    .reqIsIo    (reqIsIo),
    .reqWrite   (reqWrite),
    .reqWdata   (reqWdata),
    .adIn       (adIn),
    .curWrite   (curWrite),
    .adOut      (adOut),
    .mio        (mio),
    .dtR        (dtR),
    .rspData    (rspData)
  );

  assign adOe = strb.driveAddr || strb.driveData;

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R12
  AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R7
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (rdN && wrN && !den && !ale)); // R8

endmodule

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;

  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int NVEC   = 6;

  // {isIo, write, waits[3:0], addr[19:0], wdata[15:0], rdata[15:0]}
  localparam logic [57:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 4'd0, 20'h12345, 16'h0000, 16'hBEEF},
    {1'b0, 1'b1, 4'd0, 20'h0ABCD, 16'h1234, 16'h0000},
    {1'b1, 1'b0, 4'd2, 20'h00060, 16'h0000, 16'h55AA},
    {1'b1, 1'b1, 4'd1, 20'h003F8, 16'hA5C3, 16'h0000},
    {1'b0, 1'b0, 4'd3, 20'hFFFFF, 16'h0000, 16'h0001},
    {1'b0, 1'b1, 4'd0, 20'h00000, 16'hFFFF, 16'h0000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqIsIo = 1'b0;
  logic reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic ready = 1'b1;
  logic [DATA_W-1:0] adIn = '0;

  logic reqAccept, ale, rdN, wrN, den, dtR, mio, adOe, rspDone;
  logic [ADDR_W-1:0] adOut;
  logic [DATA_W-1:0] rspData;

  logic lReqAccept, lAle, lRdN, lWrN, lDen, lDtR, lMio, lAdOe, lRspDone;
  logic [ADDR_W-1:0] lAdOut;
  logic [DATA_W-1:0] lRspData;

  int checks = 0;
  int fails  = 0;
  logic [DATA_W-1:0] lastRd = '0;

  always #2.5 clk = ~clk;

  bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_HIGH(1'b1)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAccept(reqAccept),
    .reqAddr(reqAddr), .reqIsIo(reqIsIo), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .ready(ready), .ale(ale), .rdN(rdN), .wrN(wrN), .den(den), .dtR(dtR), .mio(mio),
    .adOut(adOut), .adOe(adOe), .adIn(adIn), .rspDone(rspDone), .rspData(rspData));

  bus_cycle_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_HIGH(1'b0)) uutLow (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAccept(lReqAccept),
    .reqAddr(reqAddr), .reqIsIo(reqIsIo), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .ready(ready), .ale(lAle), .rdN(lRdN), .wrN(lWrN), .den(lDen), .dtR(lDtR), .mio(lMio),
    .adOut(lAdOut), .adOe(lAdOe), .adIn(adIn), .rspDone(lRspDone), .rspData(lRspData));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Runs one transfer; returns at the negedge inside T4.
  // pressNext: offer a second request from T2 onward and hold it through T4.
  task automatic runCycle(input logic [57:0] v, input bit pressNext);
    logic isIo, wr;
    logic [3:0] waits;
    logic [19:0] addr;
    logic [15:0] wd, rd;
    {isIo, wr, waits, addr, wd, rd} = v;
    while (!reqAccept) @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqIsIo = isIo; reqWrite = wr; reqWdata = wd;
    ready = 1'b0; adIn = ~rd;
    @(negedge clk); // T1
    reqValid = 1'b0;
    chk("R2 ale in T1", ale, 1);
    chk("R2 adOe in T1", adOe, 1);
    chk("R2 address in T1", adOut, addr);
    chk("R2 strobes idle in T1", {rdN, wrN, den}, 3'b110);
    chk("R11 mio high-polarity", mio, isIo ? 0 : 1);
    chk("R11 mio low-polarity", lMio, isIo ? 1 : 0);
    chk("R11 dtR", dtR, wr);
    chk("R10 busy in T1", reqAccept, 0);
    @(negedge clk); // T2
    if (pressNext) begin
      reqValid = 1'b1; reqAddr = 20'h77777; reqWdata = 16'h9999; reqWrite = 1'b0; reqIsIo = 1'b0;
    end
    ready = (waits == 0);
    chk("R3 strobe in T2", {rdN, wrN}, wr ? 2'b10 : 2'b01);
    chk("R3 den in T2", den, 1);
    chk("R7/R3 adOe in T2", adOe, wr);
    if (wr) chk("R3 write data in T2", adOut, {4'h0, wd});
    chk("R1 no done in T2", rspDone, 0);
    for (int k = 1; k <= int'(waits); k++) begin
      @(negedge clk); // Tw
      chk("R4 strobe held in Tw", {rdN, wrN, den}, wr ? 3'b101 : 3'b011);
      chk("R4 no done in Tw", rspDone, 0);
      chk("R2 no ale in Tw", ale, 0);
      adIn = rd ^ 16'h0F0F;
      ready = (k == int'(waits));
    end
    @(negedge clk); // T3
    ready = 1'b0;
    chk("R3 strobe in T3", {rdN, wrN, den}, wr ? 3'b101 : 3'b011);
    chk("R1 no done in T3", rspDone, 0);
    chk("R10 no ale in T3", ale, 0);
    if (wr) chk("R10 write data kept in T3", adOut, {4'h0, wd});
    adIn = rd;
    @(negedge clk); // T4
    adIn = ~rd;
    chk("R9 done in T4", rspDone, 1);
    chk("R8 quiet in T4", {rdN, wrN, den, ale}, 4'b1100);
    chk("R7/R3 adOe in T4", adOe, wr);
    chk("R10 accept in T4", reqAccept, 1);
    if (!wr) begin
      chk("R5 read data", rspData, rd);
      lastRd = rd;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk("R8 reset strobes", {ale, rdN, wrN, den}, 4'b0110);
    chk("R7 reset adOe", adOe, 0);
    chk("R9 reset done", rspDone, 0);
    chk("R6 reset data", rspData, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 accept idle", reqAccept, 1);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      runCycle(VEC[i], 1'b0);
      @(negedge clk); // idle
      chk("R9 done single", rspDone, 0);
      chk("R7 idle adOe", adOe, 0);
      chk("R8 idle strobes", {rdN, wrN, den, ale}, 4'b1100);
      chk("R6 data held", rspData, lastRd);
    end

    // overlap of T4 and a new request
    runCycle({1'b0, 1'b1, 4'd1, 20'h23456, 16'hC0DE, 16'h0000}, 1'b1);
    @(negedge clk); // expected T1 of the second request
    reqValid = 1'b0;
    chk("R10 back-to-back ale", ale, 1);
    chk("R10 back-to-back addr", adOut, 20'h77777);
    chk("R12 exclusive strobes", {rdN, wrN}, 2'b11);
    ready = 1'b1;
    adIn = 16'h4242;
    @(negedge clk); // T2
    chk("R12 read strobe only", {rdN, wrN}, 2'b01);
    chk("R7 read release T2", adOe, 0);
    @(negedge clk); // T3
    @(negedge clk); // T4
    chk("R1 four clocks", rspDone, 1);
    chk("R5 back-to-back read", rspData, 16'h4242);
    @(negedge clk);
    chk("R9 done cleared", rspDone, 0);
    summary();
  end

endmodule